// File: doc/BRIEF.md
# Relocatable Register and RAM Window Decoder

This block sits between a CPU core's byte-wide data port and three targets: a 256-byte block of peripheral registers, a 1280-byte internal RAM, and the external bus. Every access that the core presents is steered to exactly one of these targets. The decoder holds the RAM array itself. Register-block accesses go out as a select strobe and an 8-bit offset. The external bus gets a select strobe and the full address. Read data from all three sources is merged onto a single return bus in the same cycle as the access.

Both internal windows can be moved at run time through a one-byte mapping register. This register lives inside the register block. Its two nibbles pick a 4 KiB page for each window. When both nibbles name the same page, the RAM is moved 256 bytes higher so that it begins just after the register block. The register block wins the decode wherever the two windows could meet.

Top module: `memwin_decoder`

## Requirements
- R1: After reset the mapping register reads 0x00, the register block occupies 0x0000 to 0x00FF, and the RAM occupies 0x0100 to 0x05FF.
- R2: The mapping register sits at offset 0x3D of the register block. A write stores acc_wdata, a read returns the stored byte, and reg_sel stays low for that offset.
- R3: The register-block base is bits [3:0] of the mapping register placed at address bits [15:12]. For any other offset inside those 256 bytes, reg_sel is high, reg_off equals acc_addr[7:0], and rdata returns reg_rdata.
- R4: When the two nibbles differ, the RAM base is bits [7:4] of the mapping register placed at address bits [15:12].
- R5: When the two nibbles are equal, the RAM base is that page plus 0x100, and the first 256 bytes of the page decode to the register block.
- R6: The RAM holds 1280 bytes, from base to base+0x4FF. A byte written there reads back from any later access to the same offset, including after the window moves. Base+0x500 is external.
- R7: An access outside both windows raises ext_sel for that cycle only, with ext_addr equal to acc_addr and rdata equal to ext_rdata. At most one target is selected in any cycle.
- R8: A new mapping value applies from the access after the write. The writing access itself decodes under the old mapping.
- R9: With acc_valid low, no select is raised, and neither the RAM nor the mapping register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | CPU byte address |
| acc_wdata | input | 8 | Write data |
| rdata | output | 8 | Read data merged from the selected target |
| reg_sel | output | 1 | Register-block access strobe |
| reg_off | output | 8 | Offset within the register block |
| reg_rdata | input | 8 | Read data from the register block |
| ext_sel | output | 1 | External-bus access strobe |
| ext_addr | output | 16 | External-bus address |
| ext_rdata | input | 8 | Read data from the external bus |

## Verification
A write to the mapping register does two things in one cycle: it loads a new page pair, and it is itself decoded as an access. The bench makes both happen by writing the register at its current address. It then checks that the write cycle was decoded under the old map, with no strobes raised. On the very next cycle it reads the register back at the address the new low nibble gives, and probes the old address, which must now reach the external bus. The equal-nibble case is then approached from a different page. This confirms that RAM contents survive the move and that each window's edge bytes land on the expected side.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REG  = 2'd1,
    TGT_RAM  = 2'd2,
    TGT_EXT  = 2'd3
  } tgt_e;

  typedef struct packed {
    logic [3:0] ram_page;
    logic [3:0] reg_page;
  } map_t;

endpackage

// File: rtl/memwin_map.sv
module memwin_map
  import memwin_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          REG_SPAN_LG = 8,
  parameter logic [7:0]  RESET_MAP   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output map_t              map_q,
  output logic [ADDR_W-1:0] reg_base,
  output logic [ADDR_W-1:0] ram_base
);

  localparam int PAGE_LG = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] RAM_SHIFT = ADDR_W'(1) << REG_SPAN_LG;

  map_t map_d;

  always_comb begin
    map_d = map_q;
    if (wr_en) map_d = map_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     map_q <= map_t'(RESET_MAP);
    else if (wr_en) map_q <= map_d;
  end

  always_comb begin
    reg_base = {map_q.reg_page, {PAGE_LG{1'b0}}};
    ram_base = {map_q.ram_page, {PAGE_LG{1'b0}}};
    if (map_q.ram_page == map_q.reg_page) ram_base = ram_base + RAM_SHIFT;
  end

endmodule

// File: rtl/memwin_decode.sv
module memwin_decode
  import memwin_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         REG_SPAN_LG = 8,
  parameter int         RAM_BYTES   = 1280,
  parameter int         RAM_IDX_W   = 11,
  parameter logic [7:0] MAP_OFFSET  = 8'h3D
) (
  input  logic                   valid,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [ADDR_W-1:0]      reg_base,
  input  logic [ADDR_W-1:0]      ram_base,
  output tgt_e                   tgt,
  output logic                   hit_map,
  output logic [REG_SPAN_LG-1:0] reg_off,
  output logic [RAM_IDX_W-1:0]   ram_idx
);

  localparam logic [ADDR_W-1:0] REG_SPAN = ADDR_W'(1) << REG_SPAN_LG;
  localparam logic [ADDR_W-1:0] RAM_SPAN = ADDR_W'(RAM_BYTES);

  logic [ADDR_W-1:0] reg_diff;
  logic [ADDR_W-1:0] ram_diff;
  logic              in_reg;
  logic              in_ram;

  always_comb begin
    reg_diff = addr - reg_base;
    ram_diff = addr - ram_base;
    in_reg   = reg_diff < REG_SPAN;
    in_ram   = ram_diff < RAM_SPAN;
    reg_off  = reg_diff[REG_SPAN_LG-1:0];
    ram_idx  = ram_diff[RAM_IDX_W-1:0];
    // register block outranks RAM, RAM outranks the external bus
    if (!valid)      tgt = TGT_NONE;
    else if (in_reg) tgt = TGT_REG;
    else if (in_ram) tgt = TGT_RAM;
    else             tgt = TGT_EXT;
    hit_map = (tgt == TGT_REG) && (reg_off == MAP_OFFSET[REG_SPAN_LG-1:0]);
  end

endmodule

// File: rtl/memwin_ram.sv
module memwin_ram #(
  parameter int DEPTH  = 1280,
  parameter int IDX_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
  import memwin_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         DATA_W      = 8,
  parameter int         REG_SPAN_LG = 8,
  parameter int         RAM_BYTES   = 1280,
  parameter logic [7:0] MAP_OFFSET  = 8'h3D,
  parameter logic [7:0] RESET_MAP   = 8'h00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [DATA_W-1:0]      acc_wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic                   reg_sel,
  output logic [REG_SPAN_LG-1:0] reg_off,
  input  logic [DATA_W-1:0]      reg_rdata,
  output logic                   ext_sel,
  output logic [ADDR_W-1:0]      ext_addr,
  input  logic [DATA_W-1:0]      ext_rdata
);

  localparam int RAM_IDX_W = $clog2(RAM_BYTES);

  map_t                 map_q;
  logic [ADDR_W-1:0]    reg_base;
  logic [ADDR_W-1:0]    ram_base;
  tgt_e                 tgt;
  logic                 hit_map;
  logic                 map_wr;
  logic                 ram_hit;
  logic                 ram_we;
  logic [RAM_IDX_W-1:0] ram_idx;
  logic [DATA_W-1:0]    ram_rdata;

  memwin_map #(
    .ADDR_W      (ADDR_W),
    .REG_SPAN_LG (REG_SPAN_LG),
    .RESET_MAP   (RESET_MAP)
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (map_wr),
    .wr_data  (acc_wdata[7:0]),
    .map_q    (map_q),
    .reg_base (reg_base),
    .ram_base (ram_base)
  );

  memwin_decode #(
    .ADDR_W      (ADDR_W),
    .REG_SPAN_LG (REG_SPAN_LG),
    .RAM_BYTES   (RAM_BYTES),
    .RAM_IDX_W   (RAM_IDX_W),
    .MAP_OFFSET  (MAP_OFFSET)
  ) u_dec (
    .valid    (acc_valid),
    .addr     (acc_addr),
    .reg_base (reg_base),
    .ram_base (ram_base),
    .tgt      (tgt),
    .hit_map  (hit_map),
    .reg_off  (reg_off),
    .ram_idx  (ram_idx)
  );

  memwin_ram #(
    .DEPTH  (RAM_BYTES),
    .IDX_W  (RAM_IDX_W),
    .DATA_W (DATA_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .idx   (ram_idx),
    .wdata (acc_wdata),
    .rdata (ram_rdata)
  );

  always_comb begin
    map_wr   = hit_map && acc_write;
    ram_hit  = (tgt == TGT_RAM);
    ram_we   = ram_hit && acc_write;
    reg_sel  = (tgt == TGT_REG) && !hit_map;
    ext_sel  = (tgt == TGT_EXT);
    ext_addr = acc_addr;
    unique case (tgt)
      TGT_REG: rdata = hit_map ? DATA_W'(map_q) : reg_rdata;
      TGT_RAM: rdata = ram_rdata;
      TGT_EXT: rdata = ext_rdata;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/memwin_decoder_chk.sv
module memwin_decoder_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [7:0]        acc_wdata,
  input logic              reg_sel,
  input logic              ext_sel,
  input logic              ram_hit,
  input logic              map_wr,
  input logic [7:0]        map_q
);

  // R7: one target at most
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_sel, ext_sel, ram_hit}));

  // R9: idle cycle touches nothing
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!reg_sel && !ext_sel && !ram_hit && !map_wr));

  // R8: mapping holds unless written
  p_map_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !map_wr |=> $stable(map_q));

  // R2: written byte is loaded
  p_map_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |=> (map_q == $past(acc_wdata)));

  // R3: register strobe only inside the page named by the low nibble
  p_reg_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (acc_addr[ADDR_W-1 -: 4] == map_q[3:0]));

  // R4: RAM hit lies in the page named by the high nibble
  p_ram_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_hit && (map_q[7:4] != map_q[3:0])) |-> (acc_addr[ADDR_W-1 -: 4] == map_q[7:4]));

  // R5: equal nibbles keep RAM off the first 256 bytes of the page
  p_ram_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_hit && (map_q[7:4] == map_q[3:0])) |-> (acc_addr[ADDR_W-5 -: 4] != 4'h0));

endmodule

bind memwin_decoder memwin_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata[7:0]),
  .reg_sel   (reg_sel),
  .ext_sel   (ext_sel),
  .ram_hit   (ram_hit),
  .map_wr    (map_wr),
  .map_q     (map_q)
);

// File: tb/memwin_decoder_bench.sv
module memwin_decoder_bench;

  localparam int  NV  = 32;
  localparam byte REG_RD = 8'hA5;
  // kind: 1 register, 2 RAM, 3 external, 4 mapping register
  // vector: {wr, addr[15:0], wdata[7:0], kind[2:0], exp[7:0], req[3:0]}
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 16'h0100, 8'h11, 3'd2, 8'h00, 4'd6},  // R6 write RAM low edge
    {1'b0, 16'h0100, 8'h00, 3'd2, 8'h11, 4'd1},  // R1 RAM at 0x0100
    {1'b1, 16'h05FF, 8'h22, 3'd2, 8'h00, 4'd6},  // R6 top byte
    {1'b0, 16'h05FF, 8'h00, 3'd2, 8'h22, 4'd6},  // R6
    {1'b0, 16'h0600, 8'h00, 3'd3, 8'h00, 4'd6},  // R6 one past end
    {1'b0, 16'h00FF, 8'h00, 3'd1, 8'h00, 4'd3},  // R3 last reg byte
    {1'b0, 16'h0010, 8'h00, 3'd1, 8'h00, 4'd1},  // R1
    {1'b1, 16'h003D, 8'h21, 3'd4, 8'h00, 4'd2},  // R2 map = reg p1, ram p2
    {1'b0, 16'h103D, 8'h00, 3'd4, 8'h21, 4'd8},  // R8 new map in force
    {1'b0, 16'h003D, 8'h00, 3'd3, 8'h00, 4'd8},  // R8 old place gone
    {1'b0, 16'h0000, 8'h00, 3'd3, 8'h00, 4'd3},  // R3
    {1'b1, 16'h2000, 8'h33, 3'd2, 8'h00, 4'd4},  // R4
    {1'b0, 16'h2000, 8'h00, 3'd2, 8'h33, 4'd4},  // R4
    {1'b1, 16'h24FF, 8'h44, 3'd2, 8'h00, 4'd4},  // R4
    {1'b0, 16'h24FF, 8'h00, 3'd2, 8'h44, 4'd4},  // R4
    {1'b0, 16'h2500, 8'h00, 3'd3, 8'h00, 4'd6},  // R6
    {1'b0, 16'h1FFF, 8'h00, 3'd3, 8'h00, 4'd4},  // R4
    {1'b0, 16'h10AB, 8'h00, 3'd1, 8'h00, 4'd3},  // R3
    {1'b1, 16'h103D, 8'h77, 3'd4, 8'h00, 4'd2},  // R2 equal nibbles
    {1'b0, 16'h703D, 8'h00, 3'd4, 8'h77, 4'd8},  // R8
    {1'b0, 16'h7000, 8'h00, 3'd1, 8'h00, 4'd5},  // R5 reg first
    {1'b0, 16'h7100, 8'h00, 3'd2, 8'h33, 4'd5},  // R5 RAM shifted, kept data
    {1'b0, 16'h75FF, 8'h00, 3'd2, 8'h44, 4'd5},  // R5
    {1'b0, 16'h7600, 8'h00, 3'd3, 8'h00, 4'd5},  // R5
    {1'b0, 16'h70FF, 8'h00, 3'd1, 8'h00, 4'd5},  // R5
    {1'b1, 16'h703D, 8'hF3, 3'd4, 8'h00, 4'd2},  // R2
    {1'b0, 16'hF000, 8'h00, 3'd2, 8'h33, 4'd4},  // R4
    {1'b0, 16'h3000, 8'h00, 3'd1, 8'h00, 4'd3},  // R3
    {1'b0, 16'h303D, 8'h00, 3'd4, 8'hF3, 4'd2},  // R2
    {1'b0, 16'hF500, 8'h00, 3'd3, 8'h00, 4'd6},  // R6
    {1'b1, 16'h8000, 8'h5A, 3'd3, 8'h00, 4'd7},  // R7 external write
    {1'b1, 16'h3055, 8'h66, 3'd1, 8'h00, 4'd3}   // R3 register write
  };

  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_write;
  logic [15:0] acc_addr;
  logic [7:0]  acc_wdata;
  logic [7:0]  rdata;
  logic        reg_sel;
  logic [7:0]  reg_off;
  logic [7:0]  reg_rdata;
  logic        ext_sel;
  logic [15:0] ext_addr;
  logic [7:0]  ext_rdata;

  int checks;
  int fails;
  bit done;

  memwin_decoder u_memwin_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .rdata     (rdata),
    .reg_sel   (reg_sel),
    .reg_off   (reg_off),
    .reg_rdata (reg_rdata),
    .ext_sel   (ext_sel),
    .ext_addr  (ext_addr),
    .ext_rdata (ext_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign reg_rdata = REG_RD;
  assign ext_rdata = ext_addr[15:8] ^ ext_addr[7:0];

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] wd,
                        input logic [2:0] kind, input logic [7:0] exp, input int req);
    logic [7:0] exp_rd;
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_addr  = a;
    acc_wdata = wd;
    #1;
    chk(reg_sel === (kind == 3'd1), req, "reg_sel", 16'(reg_sel), 16'(kind == 3'd1));
    chk(ext_sel === (kind == 3'd3), req, "ext_sel", 16'(ext_sel), 16'(kind == 3'd3));
    if (kind == 3'd1) chk(reg_off === a[7:0], req, "reg_off", 16'(reg_off), 16'(a[7:0]));
    if (kind == 3'd3) chk(ext_addr === a, req, "ext_addr", ext_addr, a);
    if (!wr) begin
      exp_rd = (kind == 3'd1) ? REG_RD : (kind == 3'd3) ? (a[15:8] ^ a[7:0]) : exp;
      chk(rdata === exp_rd, req, "rdata", 16'(rdata), 16'(exp_rd));
    end
    @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired: got running expected finished");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    acc_addr = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    // R9 quiet during reset
    chk(!reg_sel && !ext_sel, 9, "selects in reset", 16'({reg_sel, ext_sel}), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    // R1 reset mapping value
    access(1'b0, 16'h003D, 8'h00, 3'd4, 8'h00, 1);
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][39], VEC[i][38:23], VEC[i][22:15], VEC[i][14:12],
             VEC[i][11:4], int'(VEC[i][3:0]));
    end
    // R9 idle write to mapping register and RAM must change nothing
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 16'h303D; acc_wdata = 8'h00;
    #1;
    chk(!reg_sel && !ext_sel, 9, "idle selects", 16'({reg_sel, ext_sel}), 16'h0);
    @(negedge clk);
    acc_addr = 16'hF000; acc_wdata = 8'h99;
    @(posedge clk);
    access(1'b0, 16'h303D, 8'h00, 3'd4, 8'hF3, 9);   // R9 map unchanged
    access(1'b0, 16'hF000, 8'h00, 3'd2, 8'h33, 9);   // R9 RAM unchanged
    // R7 strobe lasts one cycle
    access(1'b0, 16'h9000, 8'h00, 3'd3, 8'h00, 7);
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
    chk(!ext_sel, 7, "ext_sel after access", 16'(ext_sel), 16'h0);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule